// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the host-facing register set of a four-channel DMA controller. A processor reaches it over a narrow 8-bit I/O bus that uses a 4-bit register offset, separate read and write strobes, and one data byte in each direction. The block stores each channel's 16-bit starting address and transfer count, together with the running copies of both. It also stores a mode byte per channel, the four channel mask bits and a command byte. It presents the configuration to the transfer engine, and it accepts the engine's running address and count so that the host can read them back.

Each 16-bit quantity is reached through a single byte-wide offset. A shared byte-pointer flip-flop picks the low or the high half. Every access to an address or count offset flips it, so software first resets it and then makes accesses in pairs, low byte first. Single-channel mask and mode writes carry the target channel number in the low two data bits rather than in the offset.

Top module: `dma_regfile`

## Requirements
- R1: After reset the byte pointer selects the low byte, all four mask bits are set, and every mode field, base address, base count and the command byte read as zero.
- R2: Offset 2n (n = 0..3) is channel n's address. Two writes store the low byte and then the high byte into both the base copy and the running copy, and the base copy appears on `base_addr[16n +: 16]`.
- R3: Offset 2n+1 is channel n's count and follows the same two-write low-then-high order into the base and running copies. The base copy appears on `base_count[16n +: 16]`.
- R4: Every read or write of offsets 0x0–0x7 flips the byte pointer. Any write to offset 0xC returns it to the low byte, whatever the data.
- R5: A read of offset 2n or 2n+1 returns the running address or count of channel n, low byte on the first access and high byte on the second.
- R6: A pulse on `eng_upd[n]` loads channel n's running address and count from the engine inputs. The base copies stay unchanged.
- R7: A write to offset 0xA changes one mask bit. Data bits [1:0] name the channel, and data bit 2 set masks it while bit 2 clear unmasks it.
- R8: A write to offset 0xB stores data bits [7:2] as the mode of the channel named by data bits [1:0], on `ch_mode[6n +: 6]`. For example 0x44 gives 0x11, 0x59 gives 0x16 on channel 1, and 0xC3 gives 0x30 on channel 3.
- R9: A write to offset 0xE clears all four mask bits. A write to offset 0xF loads them from data bits [3:0], bit n for channel n.
- R10: A write to offset 0xD is a master clear. It returns the byte pointer to the low byte, sets all mask bits and zeroes the command byte, and it leaves addresses, counts and modes untouched.
- R11: A write to offset 0x8 loads the command byte onto `cmd`. A read of offset 0x8 returns `stat_in`.
- R12: A read of any offset from 0x9 to 0xF returns zero. Reads of offsets 0x8–0xF leave the byte pointer unmoved. `rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_off | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `bus_rd` is high |
| stat_in | input | 8 | Status byte supplied by the engine |
| eng_upd | input | 4 | Per-channel load of the running copies |
| eng_addr | input | 64 | Running addresses from the engine, 16 bits per channel |
| eng_cnt | input | 64 | Running counts from the engine, 16 bits per channel |
| base_addr | output | 64 | Base address per channel |
| base_count | output | 64 | Base count per channel |
| ch_mode | output | 24 | Mode field per channel, 6 bits each |
| ch_mask | output | 4 | Mask bit per channel, 1 = masked |
| cmd | output | 8 | Command byte |

## Verification
The bench targets the byte pointer. One test interleaves a read with a write, so a design that flips the pointer only on writes lands the second byte in the wrong half. Another test clears the pointer in mid-pair, so a design that ignores offset 0xC keeps writing the high byte. A further test reads status and unused offsets and then reads an address, which catches a pointer that also moves on those offsets. Engine updates are checked through readback against the unchanged base outputs. That exposes a design that mixes up the base and running copies, or one that reads back the base values. The single-channel mask and mode writes are sent to several channels with set and clear patterns, which catches a design that decodes the channel from the wrong bits. Master clear is checked for both what it resets and what it must keep.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int BW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          bus_off,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BW-1:0]       wdata,
  output logic [BW-1:0]       rdata,
  input  logic [BW-1:0]       stat_in,
  input  logic [3:0]          eng_upd,
  input  logic [4*2*BW-1:0]   eng_addr,
  input  logic [4*2*BW-1:0]   eng_cnt,
  output logic [4*2*BW-1:0]   base_addr,
  output logic [4*2*BW-1:0]   base_count,
  output logic [4*(BW-2)-1:0] ch_mode,
  output logic [3:0]          ch_mask,
  output logic [BW-1:0]       cmd
);
  localparam int NCH = 4;
  localparam int RW  = 2 * BW;
  localparam int MW  = BW - 2;

  logic [RW-1:0] base_a [NCH];
  logic [RW-1:0] cur_a  [NCH];
  logic [RW-1:0] base_c [NCH];
  logic [RW-1:0] cur_c  [NCH];
  logic [MW-1:0] mode_q [NCH];
  logic [NCH-1:0] mask_q;
  logic [BW-1:0]  cmd_q;
  logic           hi_ptr;

  logic       data_sel;
  logic [1:0] ch;
  assign data_sel = !bus_off[3];
  assign ch       = bus_off[2:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0; cur_a[i] <= '0;
        base_c[i] <= '0; cur_c[i] <= '0;
        mode_q[i] <= '0;
      end
      mask_q <= '1;
      cmd_q  <= '0;
      hi_ptr <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (eng_upd[i]) begin
          cur_a[i] <= eng_addr[i*RW +: RW];
          cur_c[i] <= eng_cnt[i*RW +: RW];
        end
      if (bus_wr) begin
        if (data_sel) begin
          if (!bus_off[0]) begin
            if (hi_ptr) begin
              base_a[ch][RW-1:BW] <= wdata; cur_a[ch][RW-1:BW] <= wdata;
            end else begin
              base_a[ch][BW-1:0]  <= wdata; cur_a[ch][BW-1:0]  <= wdata;
            end
          end else begin
            if (hi_ptr) begin
              base_c[ch][RW-1:BW] <= wdata; cur_c[ch][RW-1:BW] <= wdata;
            end else begin
              base_c[ch][BW-1:0]  <= wdata; cur_c[ch][BW-1:0]  <= wdata;
            end
          end
          hi_ptr <= ~hi_ptr;
        end else begin
          case (bus_off)
            4'h8: cmd_q <= wdata;
            4'hA: mask_q[wdata[1:0]] <= wdata[2];
            4'hB: mode_q[wdata[1:0]] <= wdata[BW-1:2];
            4'hC: hi_ptr <= 1'b0;
            4'hD: begin hi_ptr <= 1'b0; mask_q <= '1; cmd_q <= '0; end
            4'hE: mask_q <= '0;
            4'hF: mask_q <= wdata[NCH-1:0];
            default: ;
          endcase
        end
      end else if (bus_rd && data_sel) begin
        hi_ptr <= ~hi_ptr;
      end
    end
  end

  logic [RW-1:0] rd_word;
  always_comb begin
    rd_word = bus_off[0] ? cur_c[ch] : cur_a[ch];
    rdata   = '0;
    if (bus_rd) begin
      if (data_sel)           rdata = hi_ptr ? rd_word[RW-1:BW] : rd_word[BW-1:0];
      else if (bus_off == 4'h8) rdata = stat_in;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign base_addr[g*RW +: RW]  = base_a[g];
    assign base_count[g*RW +: RW] = base_c[g];
    assign ch_mode[g*MW +: MW]    = mode_q[g];
  end
  assign ch_mask = mask_q;
  assign cmd     = cmd_q;

  a_r4_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 4'hC) |=> !hi_ptr);
  a_r10_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 4'hD) |=> (ch_mask == 4'hF && cmd == '0 && !hi_ptr));
  a_r9_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 4'hE) |=> ch_mask == 4'h0);
  a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && data_sel) |=> ($stable(base_addr) && $stable(base_count)));
  a_r12_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_wr || bus_rd) && data_sel) && !(bus_wr && (bus_off == 4'hC || bus_off == 4'hD))
    |=> $stable(hi_ptr));
  a_r12_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> rdata == '0);
endmodule

// File: tb/sim_dma_regfile.sv
module sim_dma_regfile;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_off = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] wdata = 0, rdata, stat_in = 0, cmd;
  logic [3:0] eng_upd = 0, ch_mask;
  logic [63:0] eng_addr = 0, eng_cnt = 0, base_addr, base_count;
  logic [23:0] ch_mode;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_regfile u0 (.clk, .rst_n, .bus_off, .bus_wr, .bus_rd, .wdata, .rdata, .stat_in,
    .eng_upd, .eng_addr, .eng_cnt, .base_addr, .base_count, .ch_mode, .ch_mask, .cmd);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    @(negedge clk); bus_off = o; wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] o, output logic [7:0] d);
    @(negedge clk); bus_off = o; bus_rd = 1; #1 d = rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic t_reset;
    chk("R1 mask", ch_mask, 16'hF);
    chk("R1 cmd", cmd, 0);
    chk("R1 mode", ch_mode[15:0], 0);
    chk("R1 base", base_addr[15:0] | base_count[63:48], 0);
  endtask

  task automatic t_write_regs;
    wr(4'hC, 8'h00);
    wr(4'h0, 8'h34); wr(4'h0, 8'h12);
    chk("R2 ch0 addr", base_addr[15:0], 16'h1234);
    wr(4'h4, 8'hCD); wr(4'h4, 8'hAB);
    chk("R2 ch2 addr", base_addr[47:32], 16'hABCD);
    wr(4'h3, 8'hFF); wr(4'h3, 8'h01);
    chk("R3 ch1 count", base_count[31:16], 16'h01FF);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr(4'hC, 8'h5A);
    rd(4'h3, d); chk("R5 cnt lo", d, 8'hFF);
    rd(4'h3, d); chk("R5 cnt hi", d, 8'h01);
    rd(4'h0, d); chk("R5 addr lo", d, 8'h34);
    rd(4'h0, d); chk("R5 addr hi", d, 8'h12);
  endtask

  task automatic t_pointer;
    logic [7:0] d;
    wr(4'h0, 8'h11);
    wr(4'hC, 8'hFF);
    rd(4'h0, d); chk("R4 clear then low", d, 8'h11);
    wr(4'h0, 8'h99);
    chk("R4 read flips pointer", base_addr[15:0], 16'h9911);
  endtask

  task automatic t_engine;
    logic [7:0] d;
    @(negedge clk); eng_upd = 4'b0010;
    eng_addr[31:16] = 16'h5566; eng_cnt[31:16] = 16'h0007;
    @(negedge clk); eng_upd = 0;
    wr(4'hC, 0);
    rd(4'h3, d); chk("R6 cur cnt lo", d, 8'h07);
    rd(4'h3, d); chk("R6 cur cnt hi", d, 8'h00);
    rd(4'h2, d); chk("R6 cur addr lo", d, 8'h66);
    rd(4'h2, d); chk("R6 cur addr hi", d, 8'h55);
    chk("R6 base kept", base_count[31:16], 16'h01FF);
  endtask

  task automatic t_mask_mode;
    wr(4'hA, 8'h02); chk("R7 unmask ch2", ch_mask, 16'hB);
    wr(4'hA, 8'h06); chk("R7 mask ch2", ch_mask, 16'hF);
    wr(4'hA, 8'h01); chk("R7 unmask ch1", ch_mask, 16'hD);
    wr(4'hB, 8'h44); chk("R8 ch0 mode", ch_mode[5:0], 16'h11);
    wr(4'hB, 8'h59); chk("R8 ch1 mode", ch_mode[11:6], 16'h16);
    wr(4'hB, 8'hC3); chk("R8 ch3 mode", ch_mode[23:18], 16'h30);
    chk("R8 ch0 untouched", ch_mode[5:0], 16'h11);
    wr(4'hE, 8'h00); chk("R9 clear all", ch_mask, 0);
    wr(4'hF, 8'h05); chk("R9 write all", ch_mask, 16'h5);
  endtask

  task automatic t_clear_cmd;
    logic [7:0] d;
    wr(4'h8, 8'h5A); chk("R11 cmd", cmd, 16'h5A);
    stat_in = 8'hA5;
    rd(4'h8, d); chk("R11 status", d, 8'hA5);
    wr(4'hC, 0); wr(4'h0, 8'h77);
    wr(4'hD, 8'h00);
    chk("R10 mask set", ch_mask, 16'hF);
    chk("R10 cmd zero", cmd, 0);
    chk("R10 base kept", base_addr[15:0], 16'h9977);
    chk("R10 mode kept", ch_mode[23:18], 16'h30);
    rd(4'h0, d); chk("R10 pointer low", d, 8'h77);
    rd(4'hF, d); chk("R12 read F", d, 0);
    rd(4'h9, d); chk("R12 read 9", d, 0);
    rd(4'h8, d);
    rd(4'h0, d); chk("R12 pointer unmoved", d, 8'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_write_regs; t_readback; t_pointer; t_engine; t_mask_mode; t_clear_cmd;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule